// File: doc/BRIEF.md
# Outstanding Management Request Watchdog

This block guards a class of high-priority management send requests. It keeps a running count of how many requests of that class are in flight. While that count is nonzero it runs a single countdown timer, which advances only on cycles where an external prescaler asserts a tick enable. The enqueue side reports each new request with a one-cycle pulse. The completion side reports each finished request with a dequeue pulse. An abort or shutdown path retires several requests at once with a flush pulse and a flush count.

The timer is armed only when the count leaves zero. Each retirement that leaves work pending restarts the timer from the full interval. The timer stops as soon as the count returns to zero. If the timer runs out while requests are still outstanding, the block issues a one-cycle request to cancel every send and a one-cycle request to hold the link down. The logic that carries out those two actions lives outside this block.

The interval is one twentieth of the tick rate, rounded up to whole ticks. The tick rate is given by the parameter `TICKS_PER_SEC`, so the interval is ceil(`TICKS_PER_SEC`/20).

Top module: `mgmt_req_watchdog`

## Requirements
- R1: A synchronous active-high reset sets `count_o` to 0, holds `cancel_o` and `hold_o` low and leaves the timer disarmed. After reset, no tick can produce a timeout until the count next rises from zero.
- R2: An enqueue pulse adds one to `count_o`. A dequeue pulse subtracts one. Both pulses in the same cycle leave the count unchanged. The count saturates at 2^`CNT_W`-1 and at 0.
- R3: A flush pulse subtracts `flush_cnt_i` from the count in the same update as any enqueue or dequeue pulse of that cycle. If the result would be negative, the count becomes 0.
- R4: An update that takes the count from 0 to nonzero arms the timer with INTERVAL = ceil(`TICKS_PER_SEC`/20) ticks. Absent further events, the timeout fires on the INTERVAL-th tick after arming.
- R5: An enqueue while the count is already nonzero does not restart or change the timer.
- R6: A dequeue or flush that leaves the count nonzero reloads the timer with the full interval. This includes an enqueue and a dequeue in the same cycle.
- R7: An update that leaves the count at 0 stops the timer, so no timeout follows until the timer is re-armed.
- R8: On timeout, `cancel_o` and `hold_o` are both high for exactly one cycle, the cycle after the clock edge that takes the final tick. `count_o` is unchanged. The timer then stays disarmed until an event from R4 or R6 re-arms it.
- R9: Only cycles with `tick_i` high advance the timer. Ticks seen while the timer is disarmed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enq_i | input | 1 | One watched request was queued |
| deq_i | input | 1 | One watched request completed |
| flush_i | input | 1 | Bulk retirement strobe |
| flush_cnt_i | input | CNT_W | Number of watched requests retired by the flush |
| tick_i | input | 1 | Timer advance enable from the prescaler |
| cancel_o | output | 1 | Pulse: cancel all outstanding sends |
| hold_o | output | 1 | Pulse: hold the link down |
| count_o | output | CNT_W | Number of watched requests outstanding |

## Verification
The hardest situation to reach is a timeout whose timing has been shaped by earlier events. Examples are an enqueue in the middle of the interval that must not extend the deadline, and a dequeue that must push the deadline out by a full interval. A related case is the dormant state after expiry, where the count is nonzero but the timer is disarmed. The stimulus reaches these states with directed sequences that place ticks at exact offsets from each event. A cycle-accurate behavioural model predicts the count and both pulses, and the bench compares them every clock. A long seeded random mix of pulses, flushes and ticks then interleaves these events in orders the directed cases do not cover.

// File: rtl/wd_pkg.sv
package wd_pkg;

    // Action applied to the countdown timer in a given cycle.
    typedef enum logic [1:0] {
        TA_RUN  = 2'd0,  // keep state, advance on tick
        TA_LOAD = 2'd1,  // (re)start from full interval
        TA_STOP = 2'd2   // disarm
    } tmr_act_e;

    // Ticks in one twentieth of the tick rate, rounded up.
    function automatic int unsigned wd_interval(input int unsigned ticks_per_sec);
        return (ticks_per_sec + 19) / 20;
    endfunction

endpackage

// File: rtl/wd_occupancy.sv
module wd_occupancy #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enq_i,
    input  logic             deq_i,
    input  logic             flush_i,
    input  logic [CNT_W-1:0] flush_cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    localparam int unsigned WW = CNT_W + 1;
    localparam logic [WW-1:0] MAX_W = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } occ_st_t;

    occ_st_t st_d, st_q;
    logic [WW-1:0] add_w, sub_w, diff_w;

    always_comb begin
        st_d   = st_q;
        add_w  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, enq_i};
        sub_w  = {{CNT_W{1'b0}}, deq_i}
               + (flush_i ? {1'b0, flush_cnt_i} : {WW{1'b0}});
        diff_w = add_w - sub_w;
        if (add_w < sub_w) begin
            st_d.cnt = '0;
        end else if (diff_w > MAX_W) begin
            st_d.cnt = {CNT_W{1'b1}};
        end else begin
            st_d.cnt = diff_w[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;

    // R2
    idle_count_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enq_i && !deq_i && !flush_i) |=> $stable(cnt_o));

    // R3
    flush_never_raises_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (flush_i && !enq_i) |=> (cnt_o <= $past(cnt_o)));

endmodule

// File: rtl/wd_interval_timer.sv
module wd_interval_timer
    import wd_pkg::*;
#(
    parameter int unsigned INTERVAL = 50,
    parameter int unsigned TW       = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  tmr_act_e      act_i,
    input  logic          tick_i,
    output logic          armed_o,
    output logic [TW-1:0] remain_o,
    output logic          fire_o
);
    localparam logic [TW-1:0] FULL_V = TW'(INTERVAL);
    localparam logic [TW-1:0] ONE_V  = TW'(1);

    typedef struct packed {
        logic          armed;
        logic [TW-1:0] remain;
        logic          fire;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        case (act_i)
            TA_LOAD: begin
                st_d.armed  = 1'b1;
                st_d.remain = FULL_V;
            end
            TA_STOP: begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
            end
            default: begin
                if (st_q.armed && tick_i) begin
                    if (st_q.remain == ONE_V) begin
                        st_d.armed  = 1'b0;
                        st_d.remain = '0;
                        st_d.fire   = 1'b1;
                    end else begin
                        st_d.remain = st_q.remain - ONE_V;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o  = st_q.armed;
    assign remain_o = st_q.remain;
    assign fire_o   = st_q.fire;

    // R8
    fire_single_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |=> !fire_o);

    // R9
    no_tick_no_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i == TA_RUN && !tick_i) |=> ($stable(remain_o) && !fire_o));

    // R4
    remain_bounded_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        armed_o |-> (remain_o <= FULL_V && remain_o != '0));

endmodule

// File: rtl/mgmt_req_watchdog.sv
module mgmt_req_watchdog
    import wd_pkg::*;
#(
    parameter int unsigned CNT_W         = 8,
    parameter int unsigned TICKS_PER_SEC = 1000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enq_i,
    input  logic             deq_i,
    input  logic             flush_i,
    input  logic [CNT_W-1:0] flush_cnt_i,
    input  logic             tick_i,
    output logic             cancel_o,
    output logic             hold_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned INTERVAL = wd_interval(TICKS_PER_SEC);
    localparam int unsigned TW       = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] FULL_V = TW'(INTERVAL);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    tmr_act_e         act;
    logic             armed;
    logic [TW-1:0]    remain;
    logic             fire;

    wd_occupancy #(
        .CNT_W (CNT_W)
    ) occ_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .enq_i       (enq_i),
        .deq_i       (deq_i),
        .flush_i     (flush_i),
        .flush_cnt_i (flush_cnt_i),
        .cnt_o       (cnt_q),
        .cnt_nxt_o   (cnt_nxt)
    );

    // Timer action from the count transition of this cycle.
    always_comb begin
        if (cnt_nxt == '0) begin
            act = TA_STOP;
        end else if (deq_i || flush_i) begin
            act = TA_LOAD;
        end else if (cnt_q == '0) begin
            act = TA_LOAD;
        end else begin
            act = TA_RUN;
        end
    end

    wd_interval_timer #(
        .INTERVAL (INTERVAL),
        .TW       (TW)
    ) tmr_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .act_i    (act),
        .tick_i   (tick_i),
        .armed_o  (armed),
        .remain_o (remain),
        .fire_o   (fire)
    );

    assign cancel_o = fire;
    assign hold_o   = fire;
    assign count_o  = cnt_q;

    // R7
    idle_disarmed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o == '0) |-> !armed);

    // R8
    fire_needs_work_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_o |-> (count_o != '0 && !armed));

    // R5
    enq_keeps_timer_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (enq_i && !deq_i && !flush_i && count_o != '0 && !tick_i) |=> $stable(remain));

    // R6
    deq_reloads_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (deq_i && !flush_i && count_o > 1) |=> (armed && remain == FULL_V));

    // R4
    first_enq_arms_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (enq_i && !deq_i && !flush_i && count_o == '0) |=> (armed && remain == FULL_V));

endmodule

// File: tb/mgmt_req_watchdog_tb_top.sv
`timescale 1ns/1ps
module mgmt_req_watchdog_tb_top;
    localparam int CW   = 3;
    localparam int MAXC = 7;
    localparam int IVL  = 5;   // ceil(90/20)

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq = 1'b0, deq = 1'b0, fl = 1'b0, tick = 1'b0;
    logic [CW-1:0] fc = '0;
    logic          cancel, hold;
    logic [CW-1:0] count;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state
    int  m_cnt = 0;
    bit  m_armed = 0;
    int  m_rem = 0;
    bit  m_pulse = 0;
    int  pulses_seen = 0;

    always #5 clk = ~clk;

    mgmt_req_watchdog #(.CNT_W(CW), .TICKS_PER_SEC(90)) dut_i (
        .clk_i(clk), .rst_i(rst), .enq_i(enq), .deq_i(deq), .flush_i(fl),
        .flush_cnt_i(fc), .tick_i(tick), .cancel_o(cancel), .hold_o(hold),
        .count_o(count)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit r, input bit e, input bit d, input bit f,
                              input int n, input bit t);
        int nxt;
        m_pulse = 0;
        if (r) begin
            m_cnt = 0; m_armed = 0; m_rem = 0;
            return;
        end
        nxt = m_cnt + int'(e) - int'(d) - (f ? n : 0);
        if (nxt < 0) nxt = 0;
        if (nxt > MAXC) nxt = MAXC;
        if (nxt == 0) begin
            m_armed = 0;
        end else if (d || f || m_cnt == 0) begin
            m_armed = 1; m_rem = IVL;
        end else if (m_armed && t) begin
            m_rem--;
            if (m_rem == 0) begin
                m_armed = 0; m_pulse = 1;
            end
        end
        m_cnt = nxt;
    endtask

    task automatic step(input bit r, input bit e, input bit d, input bit f,
                        input int n, input bit t);
        @(negedge clk);
        rst = r; enq = e; deq = d; fl = f; fc = CW'(n); tick = t;
        model_step(r, e, d, f, n, t);
        @(posedge clk);
        #1;
        chk("count_o", int'(count), m_cnt);
        chk("cancel_o", int'(cancel), int'(m_pulse));
        chk("hold_o", int'(hold), int'(m_pulse));
        if (cancel) pulses_seen++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            step(0, 0, 0, 0, 0, 1);
            step(0, 0, 0, 0, 0, 0);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int p0;
        // R1: reset state
        tag = "R1";
        step(1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        ticks(IVL + 2);

        // R4: arm on 0->1, fire on 5th tick; R9 idle cycles between ticks
        tag = "R4";
        p0 = pulses_seen;
        step(0, 1, 0, 0, 0, 0);
        idle(3);
        ticks(IVL - 1);
        chk("no pulse before interval", pulses_seen - p0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("pulse at interval", pulses_seen - p0, 1);

        // R8: dormant after expiry, count kept
        tag = "R8";
        ticks(IVL * 2);
        chk("count kept after expiry", int'(count), 1);
        chk("no re-fire while dormant", pulses_seen - p0, 1);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);   // leaves 1 -> re-arm
        p0 = pulses_seen;
        ticks(IVL);
        chk("re-armed by dequeue", pulses_seen - p0, 1);
        step(0, 0, 1, 0, 0, 0);   // count to 0

        // R5: mid-interval enqueue does not extend deadline
        tag = "R5";
        p0 = pulses_seen;
        step(0, 1, 0, 0, 0, 0);
        ticks(3);
        step(0, 1, 0, 0, 0, 1);   // enqueue with a tick
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("original deadline kept", pulses_seen - p0, 1);
        chk("count after three enqueues", int'(count), 3);

        // R6: dequeue reloads full interval
        tag = "R6";
        step(0, 0, 1, 0, 0, 0);   // 2 left, reload
        p0 = pulses_seen;
        ticks(IVL - 1);
        chk("no pulse before reloaded deadline", pulses_seen - p0, 0);
        step(0, 1, 1, 0, 0, 0);   // same-cycle enq+deq: reload, count same
        chk("enq+deq leaves count", int'(count), 2);
        ticks(IVL - 1);
        chk("enq+deq reloaded", pulses_seen - p0, 0);
        step(0, 0, 0, 1, 1, 0);   // flush 1 leaves 1: reload
        ticks(IVL - 1);
        chk("flush reloaded", pulses_seen - p0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("pulse after reload", pulses_seen - p0, 1);

        // R7: count to zero stops timer
        tag = "R7";
        step(0, 1, 0, 0, 0, 0);
        ticks(2);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        p0 = pulses_seen;
        ticks(IVL * 2);
        chk("no pulse after drain", pulses_seen - p0, 0);
        step(0, 1, 0, 0, 0, 0);
        ticks(IVL - 1);
        step(0, 0, 1, 0, 0, 1);   // drain on final tick
        chk("drain wins over final tick", pulses_seen - p0, 0);

        // R2: saturation both ends
        tag = "R2";
        for (int i = 0; i < MAXC + 2; i++) step(0, 1, 0, 0, 0, 0);
        chk("saturate high", int'(count), MAXC);
        // R3: flush subtracts, clamps at zero
        tag = "R3";
        step(0, 0, 0, 1, 3, 0);
        chk("flush by 3", int'(count), 4);
        step(0, 1, 1, 1, 2, 0);
        chk("flush with enq+deq", int'(count), 2);
        step(0, 0, 1, 1, 6, 0);
        chk("flush clamp", int'(count), 0);
        tag = "R2";
        step(0, 0, 1, 0, 0, 0);
        chk("saturate low", int'(count), 0);
        step(0, 1, 1, 0, 0, 0);
        chk("enq+deq at zero", int'(count), 0);

        // R9: random mix against model
        tag = "R9";
        void'($urandom(7));
        for (int i = 0; i < 3000; i++) begin
            int rv = int'($urandom_range(99, 0));
            step(0, rv < 35, ($urandom_range(99, 0) < 22), rv > 95,
                 int'($urandom_range(3, 0)), ($urandom_range(1, 0) == 1));
        end

        // R1: reset in mid-run
        tag = "R1";
        step(0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1);
        chk("count after reset", int'(count), 0);
        ticks(IVL * 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule